// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block sits between a host-side request port and a small-page NAND flash device with a shared 8-bit command/address/data bus. The host presents one operation at a time: page read, page program, block erase, internal copy-back or device identification. It supplies a 27-bit byte address, plus a target address for copy-back and a byte count for transfers. The block drives the chip-enable, command-latch, address-latch, write-strobe and read-strobe lines. It places each command byte, address byte and data byte on the bus, then waits for the device's ready/busy line and reports the outcome with a one-cycle `done` or `err` pulse.

Every strobe timing is derived at elaboration from a clock-period parameter and nanosecond minima, with each value rounded up to whole clock cycles. The device's 528-byte page is addressed as a column byte (A0..A7), a half-page bit (A8) and an 18-bit row (A9..A26). A8 never appears on the bus. It selects the pointer command issued before a read or program. Write data enters through a valid/ready byte stream. Read data leaves through a valid/ready byte stream that stalls the read strobe when the host stops accepting.

Top module: `nand_seq`

## Requirements
- R1: After reset `req_ready` stays low for ceil(T_POR_NS/CLK_NS) clock cycles (125 at the defaults). No request can be accepted and no strobe can move during that time.
- R2: Each full address is sent as four address-latch cycles: A[7:0], then A[16:9], then A[24:17], then {6'b0, A[26:25]}. Bit A8 is never placed on the bus.
- R3: A read or program begins with the pointer command 0x00 when A8 is 0 and 0x01 when A8 is 1.
- R4: Command bytes are latched with CLE=1 and ALE=0, address bytes with ALE=1 and CLE=0, and data with both low, all on the rising edge of WE#. WE# stays low for at least ceil(T_WP_NS/CLK_NS) cycles (4 at the defaults). Successive WE# falling edges are at least ceil(T_CYC_NS/CLK_NS) cycles apart (7). CE# stays low only while an operation runs. WE# and RE# are never low together.
- R5: RE# falls only after CLE has been low for at least ceil(T_CLR_NS/CLK_NS) cycles (7).
- R6: Program (op 1) issues the pointer command, 0x80, four address bytes, `req_len` data bytes taken in order from the write stream, then 0x10, and waits for ready.
- R7: Erase (op 2) issues 0x60, only the three row address bytes (cycles 2 to 4 of R2), then 0xD0, and waits for ready.
- R8: Copy-back (op 3) issues 0x00, four source address bytes, waits for ready, then issues 0x8A, four target address bytes and 0x10, and waits again. If bits A14, A15 or A26 differ between source and target, the request is answered with `err` in the cycle after acceptance, and CE# never falls.
- R9: Each wait ignores ready/busy for ceil(T_WB_NS/CLK_NS) cycles and then waits for it to be high. No strobe falls while the device is busy. If the line stays low for TO_CYC cycles, the operation ends with `err`.
- R10: Identify (op 4) issues 0x90 and one address byte 0x00, then reads two bytes. It ends with `done` when the second byte equals DEV_ID (0x79), and with `err` otherwise.
- R11: Read (op 0) issues the pointer command and four address bytes, waits for ready, then reads `req_len` bytes in order onto the read stream. `rd_data` holds steady while `rd_valid` is high and `rd_ready` is low. RE# does not fall while an undelivered byte is held.
- R12: `done` and `err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_op | input | 3 | 0 read, 1 program, 2 erase, 3 copy-back, 4 identify |
| req_src | input | 27 | Byte address (source for copy-back) |
| req_dst | input | 27 | Copy-back target address |
| req_len | input | LENW | Number of data bytes for read or program |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte valid |
| wr_ready | output | 1 | Sequencer takes the data byte |
| rd_data | output | 8 | Byte read from the device |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Host accepts the read byte |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Bus value driven to the device |
| nf_dq_oe | output | 1 | Bus drive enable |
| nf_dq_i | input | 8 | Bus value from the device |
| nf_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
Two functions can act in the same clock. One is the read strobe's decision to start a new byte; the other is the host's retirement of the byte already held. The bench provokes this by toggling `rd_ready` on a fixed pattern during multi-byte reads, so acceptance sometimes lands in the very cycle the sequencer looks at its holding register. It judges the result by requiring every byte to arrive exactly once and in order, and by requiring the read strobe to never fall with a byte still held. The same kind of overlap between ready/busy timing out and the device going ready is provoked with a busy period longer than the timeout. The judge there is that only `err` fires, once.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int CLK_NS    = 8,
  parameter int T_WP_NS   = 25,
  parameter int T_WH_NS   = 15,
  parameter int T_RP_NS   = 25,
  parameter int T_REH_NS  = 15,
  parameter int T_CYC_NS  = 50,
  parameter int T_CLR_NS  = 50,
  parameter int T_WB_NS   = 100,
  parameter int T_POR_NS  = 1000,
  parameter int TO_CYC    = 400000,
  parameter int LENW      = 10,
  parameter logic [7:0] DEV_ID = 8'h79
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [26:0]     req_src,
  input  logic [26:0]     req_dst,
  input  logic [LENW-1:0] req_len,
  input  logic [7:0]      wr_data,
  input  logic            wr_valid,
  output logic            wr_ready,
  output logic [7:0]      rd_data,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic            done,
  output logic            err,
  output logic            nf_ce_n,
  output logic            nf_cle,
  output logic            nf_ale,
  output logic            nf_we_n,
  output logic            nf_re_n,
  output logic [7:0]      nf_dq_o,
  output logic            nf_dq_oe,
  input  logic [7:0]      nf_dq_i,
  input  logic            nf_rb
);
  localparam int CYC  = (T_CYC_NS + CLK_NS - 1) / CLK_NS;
  localparam int WLO  = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int WH0  = (T_WH_NS + CLK_NS - 1) / CLK_NS;
  localparam int WHI  = (WH0 > CYC - WLO) ? WH0 : CYC - WLO;
  localparam int RLO  = (T_RP_NS + CLK_NS - 1) / CLK_NS;
  localparam int RH0  = (T_REH_NS + CLK_NS - 1) / CLK_NS;
  localparam int RHI  = (RH0 > CYC - RLO) ? RH0 : CYC - RLO;
  localparam int CLR  = (T_CLR_NS + CLK_NS - 1) / CLK_NS;
  localparam int WB   = (T_WB_NS + CLK_NS - 1) / CLK_NS;
  localparam int POR  = (T_POR_NS + CLK_NS - 1) / CLK_NS;
  localparam int TW   = $clog2(TO_CYC + WB + CYC + 2);
  localparam int CW   = $clog2(CLR + 1) + 1;
  localparam int PW   = $clog2(POR + 1) + 1;

  localparam logic [TW-1:0] WLO_T = TW'(WLO - 1);
  localparam logic [TW-1:0] WHI_T = TW'(WHI - 1);
  localparam logic [TW-1:0] RLO_T = TW'(RLO - 1);
  localparam logic [TW-1:0] RHI_T = TW'(RHI - 1);
  localparam logic [TW-1:0] WB_T  = TW'(WB - 1);
  localparam logic [TW-1:0] TO_T  = TW'(TO_CYC - 1);
  localparam logic [CW-1:0] CLR_C = CW'(CLR);
  localparam logic [PW-1:0] POR_C = PW'(POR);

  localparam logic [2:0] K_CMD = 3'd0, K_ADR = 3'd1, K_WR = 3'd2, K_RD = 3'd3,
                         K_WT  = 3'd4, K_ID  = 3'd5, K_END = 3'd6;
  localparam logic [2:0] OP_RD = 3'd0, OP_PG = 3'd1, OP_ER = 3'd2, OP_CB = 3'd3, OP_ID = 3'd4;

  function automatic logic [10:0] act(input logic [2:0] op, input logic [3:0] s, input logic a8);
    logic [7:0] ptr;
    ptr = {7'b0, a8};
    act = {K_END, 8'h00};
    case (op)
      OP_RD: case (s)
        4'd0: act = {K_CMD, ptr};
        4'd1, 4'd2, 4'd3, 4'd4: act = {K_ADR, 6'b0, 2'(s - 4'd1)};
        4'd5: act = {K_WT, 8'h00};
        4'd6: act = {K_RD, 8'h00};
        default: ;
      endcase
      OP_PG: case (s)
        4'd0: act = {K_CMD, ptr};
        4'd1: act = {K_CMD, 8'h80};
        4'd2, 4'd3, 4'd4, 4'd5: act = {K_ADR, 6'b0, 2'(s - 4'd2)};
        4'd6: act = {K_WR, 8'h00};
        4'd7: act = {K_CMD, 8'h10};
        4'd8: act = {K_WT, 8'h00};
        default: ;
      endcase
      OP_ER: case (s)
        4'd0: act = {K_CMD, 8'h60};
        4'd1, 4'd2, 4'd3: act = {K_ADR, 6'b0, 2'(s)};
        4'd4: act = {K_CMD, 8'hD0};
        4'd5: act = {K_WT, 8'h00};
        default: ;
      endcase
      OP_CB: case (s)
        4'd0: act = {K_CMD, 8'h00};
        4'd1, 4'd2, 4'd3, 4'd4: act = {K_ADR, 6'b0, 2'(s - 4'd1)};
        4'd5: act = {K_WT, 8'h00};
        4'd6: act = {K_CMD, 8'h8A};
        4'd7, 4'd8, 4'd9, 4'd10: act = {K_ADR, 5'b0, 1'b1, 2'(s - 4'd7)};
        4'd11: act = {K_CMD, 8'h10};
        4'd12: act = {K_WT, 8'h00};
        default: ;
      endcase
      OP_ID: case (s)
        4'd0: act = {K_CMD, 8'h90};
        4'd1: act = {K_ADR, 8'h80};
        4'd2: act = {K_ID, 8'h00};
        default: ;
      endcase
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] abyte(input logic [26:0] a, input logic [1:0] c);
    case (c)
      2'd0:    abyte = a[7:0];
      2'd1:    abyte = a[16:9];
      2'd2:    abyte = a[24:17];
      default: abyte = {6'b0, a[26:25]};
    endcase
  endfunction

  logic            busy;
  logic [2:0]      op_q;
  logic [26:0]     src_q, dst_q;
  logic [LENW-1:0] len_q, cnt;
  logic [3:0]      step;
  logic [1:0]      ph;
  logic [TW-1:0]   tmr;
  logic [CW-1:0]   clr_cnt;
  logic [PW-1:0]   por_cnt;
  logic [7:0]      wbyte;
  logic            id_ok;
  logic [10:0]     cur;
  logic [2:0]      kind;
  logic [7:0]      val, adr_b;
  logic            cb_bad, op_bad, last_b;

  assign cur    = act(op_q, step, src_q[8]);
  assign kind   = cur[10:8];
  assign val    = cur[7:0];
  assign adr_b  = val[7] ? 8'h00 : abyte(val[2] ? dst_q : src_q, val[1:0]);

  assign nf_ce_n  = !busy;
  assign nf_cle   = busy && kind == K_CMD;
  assign nf_ale   = busy && kind == K_ADR;
  assign nf_dq_o  = (kind == K_CMD) ? val : (kind == K_ADR) ? adr_b : wbyte;
  assign nf_dq_oe = nf_cle || nf_ale || (busy && kind == K_WR && ph != 2'd0);
  assign wr_ready = busy && kind == K_WR && ph == 2'd0;
  assign req_ready = (por_cnt == POR_C) && !busy && !rd_valid;

  assign cb_bad = req_op == OP_CB &&
                  ({req_src[26], req_src[15:14]} != {req_dst[26], req_dst[15:14]});
  assign op_bad = req_op > OP_ID;
  assign last_b = (kind == K_ID) ? (cnt == LENW'(1)) : (cnt == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_cnt <= '0;
      clr_cnt <= CLR_C;
    end else begin
      if (por_cnt != POR_C) por_cnt <= por_cnt + 1'b1;
      if (nf_cle) clr_cnt <= '0;
      else if (clr_cnt != CLR_C) clr_cnt <= clr_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; op_q <= '0; src_q <= '0; dst_q <= '0; len_q <= '0;
      cnt <= '0; step <= '0; ph <= '0; tmr <= '0; wbyte <= '0; id_ok <= 1'b0;
      nf_we_n <= 1'b1; nf_re_n <= 1'b1;
      rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (!busy) begin
        if (req_valid && req_ready) begin
          if (cb_bad || op_bad) err <= 1'b1;
          else begin
            busy <= 1'b1; op_q <= req_op; src_q <= req_src; dst_q <= req_dst;
            len_q <= req_len; step <= '0; ph <= '0; cnt <= '0; id_ok <= 1'b0;
          end
        end
      end else begin
        case (kind)
          K_CMD, K_ADR, K_WR: begin
            if (ph == 2'd0) begin
              if (kind != K_WR || wr_valid) begin
                if (kind == K_WR) wbyte <= wr_data;
                nf_we_n <= 1'b0; tmr <= WLO_T; ph <= 2'd1;
              end
            end else if (ph == 2'd1) begin
              if (tmr == '0) begin nf_we_n <= 1'b1; tmr <= WHI_T; ph <= 2'd2; end
              else tmr <= tmr - 1'b1;
            end else begin
              if (tmr == '0) begin
                ph <= 2'd0;
                if (kind == K_WR && cnt != len_q - 1'b1) cnt <= cnt + 1'b1;
                else begin cnt <= '0; step <= step + 1'b1; end
              end else tmr <= tmr - 1'b1;
            end
          end
          K_RD, K_ID: begin
            if (ph == 2'd0) begin
              if ((kind == K_ID || !rd_valid) && clr_cnt >= CLR_C) begin
                nf_re_n <= 1'b0; tmr <= RLO_T; ph <= 2'd1;
              end
            end else if (ph == 2'd1) begin
              if (tmr == '0) begin
                nf_re_n <= 1'b1; tmr <= RHI_T; ph <= 2'd2;
                if (kind == K_RD) begin rd_data <= nf_dq_i; rd_valid <= 1'b1; end
                else if (cnt == LENW'(1)) id_ok <= (nf_dq_i == DEV_ID);
              end else tmr <= tmr - 1'b1;
            end else begin
              if (tmr == '0) begin
                ph <= 2'd0;
                if (last_b) begin cnt <= '0; step <= step + 1'b1; end
                else cnt <= cnt + 1'b1;
              end else tmr <= tmr - 1'b1;
            end
          end
          K_WT: begin
            if (ph == 2'd0) begin
              tmr <= WB_T; ph <= 2'd1;
            end else if (ph == 2'd1) begin
              if (tmr == '0) ph <= 2'd2;
              else tmr <= tmr - 1'b1;
            end else begin
              if (nf_rb) begin ph <= 2'd0; tmr <= '0; step <= step + 1'b1; end
              else if (tmr == TO_T) begin err <= 1'b1; busy <= 1'b0; end
              else tmr <= tmr + 1'b1;
            end
          end
          default: begin
            busy <= 1'b0;
            if (op_q == OP_ID && !id_ok) err <= 1'b1;
            else done <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

module nand_seq_chk #(
  parameter int CLK_NS   = 8,
  parameter int T_POR_NS = 1000,
  parameter int T_CLR_NS = 50
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_op,
  input logic [26:0] req_src,
  input logic [26:0] req_dst,
  input logic [7:0]  rd_data,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic        done,
  input logic        err,
  input logic        nf_ce_n,
  input logic        nf_cle,
  input logic        nf_ale,
  input logic        nf_we_n,
  input logic        nf_re_n,
  input logic        nf_dq_oe
);
  localparam int POR = (T_POR_NS + CLK_NS - 1) / CLK_NS;
  localparam int CLR = (T_CLR_NS + CLK_NS - 1) / CLK_NS;

  int up_cnt, low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cnt  <= 0;
      low_cnt <= CLR;
    end else begin
      if (up_cnt < POR) up_cnt <= up_cnt + 1;
      if (nf_cle) low_cnt <= 0;
      else if (low_cnt < CLR) low_cnt <= low_cnt + 1;
    end
  end

  assert_por_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt < POR) |-> !req_ready);
  assert_latch_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nf_ce_n |-> (nf_we_n && nf_re_n && !nf_dq_oe));
  assert_clr_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_re_n) |-> (low_cnt >= CLR));
  assert_cb_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 3'd3 &&
     {req_src[26], req_src[15:14]} != {req_dst[26], req_dst[15:14]}) |=> (err && nf_ce_n));
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind nand_seq nand_seq_chk #(.CLK_NS(CLK_NS), .T_POR_NS(T_POR_NS), .T_CLR_NS(T_CLR_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .req_src(req_src), .req_dst(req_dst), .rd_data(rd_data), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .done(done), .err(err), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle),
  .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_oe(nf_dq_oe));

// File: tb/nand_seq_tb.sv
module nand_seq_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [26:0] req_src = '0, req_dst = '0;
  logic [9:0]  req_len = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [7:0]  rd_data;
  logic        rd_valid, rd_ready = 1'b0;
  logic        done, err;
  logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0]  nf_dq_o;
  logic [7:0]  mdq = 8'h00;
  logic        rb = 1'b1;

  nand_seq #(.TO_CYC(300)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_src(req_src), .req_dst(req_dst), .req_len(req_len), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .done(done), .err(err), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle),
    .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o),
    .nf_dq_oe(nf_dq_oe), .nf_dq_i(mdq), .nf_rb(rb));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // flash model
  logic [9:0] ev_q[$];
  logic [9:0] exp_q[$];
  logic [7:0] wq[$];
  logic [7:0] got_q[$];
  logic [7:0] last_cmd = 8'hFF;
  logic [7:0] id_dev = 8'h79;
  int acnt = 0, rd_idx = 0, busy_len = 40;
  event bz;

  always @(posedge nf_we_n) if (nf_ce_n === 1'b0) begin
    ev_q.push_back({nf_cle, nf_ale, nf_dq_o});
    if (nf_cle) begin
      last_cmd = nf_dq_o; acnt = 0; rd_idx = 0;
      if (nf_dq_o == 8'h10 || nf_dq_o == 8'hD0) -> bz;
    end else if (nf_ale) begin
      acnt++;
      if ((last_cmd == 8'h00 || last_cmd == 8'h01) && acnt == 4) -> bz;
    end
  end

  always begin
    @bz;
    repeat (3) @(negedge clk);
    rb = 1'b0;
    repeat (busy_len) @(negedge clk);
    rb = 1'b1;
  end

  always @(negedge nf_re_n) begin
    if (last_cmd == 8'h90) mdq = (rd_idx == 0) ? 8'hEC : id_dev;
    else mdq = 8'(rd_idx * 7 + 3);
    rd_idx++;
  end

  // streams
  int tick = 0;
  bit whs = 0, rhs = 0;
  always @(negedge clk) begin
    tick++;
    if (whs) void'(wq.pop_front());
    wr_valid = (wq.size() > 0) && (tick % 3 != 0);
    wr_data  = (wq.size() > 0) ? wq[0] : 8'h00;
    whs = wr_valid && wr_ready;
    if (rhs) got_q.push_back(rd_data);
    rd_ready = (tick % 4 != 1);
    rhs = rd_valid && rd_ready;
  end

  // protocol monitor
  int we_lo = 0, since_wf = 100, clr_c = 100;
  logic we_p = 1'b1, re_p = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (nf_cle) clr_c = 0; else clr_c++;
    if (!nf_ce_n) chk(!(nf_cle && nf_ale), "R4", "CLE and ALE together", {nf_cle, nf_ale}, 0);
    if (!nf_we_n) begin
      if (we_p) begin
        chk(since_wf >= 7, "R4", "byte period", since_wf, 7);
        chk(rb, "R9", "WE# fell while busy", rb, 1);
        since_wf = 0;
      end
      we_lo++;
    end else if (!we_p) begin
      chk(we_lo >= 4, "R4", "WE# low width", we_lo, 4);
      we_lo = 0;
    end
    since_wf++;
    if (!nf_re_n && re_p) begin
      chk(clr_c >= 7, "R5", "CLE-to-RE# gap", clr_c, 7);
      chk(!rd_valid, "R11", "RE# fell with byte held", rd_valid, 0);
      chk(rb, "R9", "RE# fell while busy", rb, 1);
    end
    if (nf_ce_n) chk(nf_we_n && nf_re_n, "R4", "strobe with CE# high", {nf_we_n, nf_re_n}, 3);
    if (done || err) chk(!(done && err), "R12", "done with err", {done, err}, 2);
    we_p = nf_we_n; re_p = nf_re_n;
  end

  function automatic logic [7:0] ab(input logic [26:0] a, input int c);
    case (c)
      0: ab = a[7:0];
      1: ab = a[16:9];
      2: ab = a[24:17];
      default: ab = {6'b0, a[26:25]};
    endcase
  endfunction

  task automatic pc(input logic [7:0] b); exp_q.push_back({2'b10, b}); endtask
  task automatic pa(input logic [7:0] b); exp_q.push_back({2'b01, b}); endtask

  task automatic run_op(input logic [2:0] op, input logic [26:0] s, input logic [26:0] d,
                        input int len, input bit exp_err, input string rq);
    int n;
    bit nobus;
    logic [7:0] ptr;
    ptr = s[8] ? 8'h01 : 8'h00;
    nobus = (op == 3'd3) && ({s[26], s[15:14]} != {d[26], d[15:14]});
    exp_q.delete(); ev_q.delete(); got_q.delete();
    if (!nobus) case (op)
      3'd0: begin pc(ptr); for (int c = 0; c < 4; c++) pa(ab(s, c)); end
      3'd1: begin
        pc(ptr); pc(8'h80); for (int c = 0; c < 4; c++) pa(ab(s, c));
        for (int i = 0; i < len; i++) begin
          wq.push_back(8'(8'hA0 + i * 3)); exp_q.push_back({2'b00, 8'(8'hA0 + i * 3)});
        end
        pc(8'h10);
      end
      3'd2: begin pc(8'h60); for (int c = 1; c < 4; c++) pa(ab(s, c)); pc(8'hD0); end
      3'd3: begin
        pc(8'h00); for (int c = 0; c < 4; c++) pa(ab(s, c));
        pc(8'h8A); for (int c = 0; c < 4; c++) pa(ab(d, c)); pc(8'h10);
      end
      default: begin pc(8'h90); pa(8'h00); end
    endcase
    @(negedge clk);
    req_op = op; req_src = s; req_dst = d; req_len = 10'(len); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && !err && n < 5000) begin @(negedge clk); n++; end
    chk(done == !exp_err && err == exp_err, rq, "outcome {done,err}", {done, err}, {!exp_err, exp_err});
    @(negedge clk);
    chk(!done && !err, "R12", "pulse lasts one cycle", {done, err}, 0);
    if (nobus) chk(nf_ce_n, "R8", "CE# after reject", nf_ce_n, 1);
    n = 0;
    while ((!rb || rd_valid) && n < 3000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk(ev_q.size() == exp_q.size(), rq, "bus cycle count", ev_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < ev_q.size(); i++)
      chk(ev_q[i] == exp_q[i], rq, $sformatf("bus cycle %0d {cle,ale,byte}", i), ev_q[i], exp_q[i]);
    if (op == 3'd0 && !exp_err) begin
      chk(got_q.size() == len, "R11", "read byte count", got_q.size(), len);
      for (int i = 0; i < len && i < got_q.size(); i++)
        chk(got_q[i] == 8'(i * 7 + 3), "R11", $sformatf("read byte %0d", i), got_q[i], 8'(i * 7 + 3));
    end
    if (op == 3'd1) chk(wq.size() == 0, "R6", "write stream drained", wq.size(), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    // reset state
    chk(nf_ce_n && nf_we_n && nf_re_n && !nf_dq_oe, "R4", "reset strobes",
        {nf_ce_n, nf_we_n, nf_re_n, nf_dq_oe}, 4'b1110);
    chk(!done && !err && !req_ready && !rd_valid, "R12", "reset flags",
        {done, err, req_ready, rd_valid}, 0);
    rst_n = 1'b1;
    n = 0;
    while (!req_ready && n < 1000) begin
      @(negedge clk); n++;
      if (!nf_ce_n) chk(0, "R1", "CE# during power-up", 0, 1);
    end
    chk(n == 125, "R1", "power-up wait cycles", n, 125);

    run_op(3'd0, 27'h2A5_3C_77 & ~27'h100, 27'h0, 5, 0, "R2 R3 R11 read A8=0");
    run_op(3'd0, 27'h5_5A_1C4 | 27'h100, 27'h0, 3, 0, "R3 read A8=1");
    run_op(3'd1, 27'h7_3F_1A5, 27'h0, 6, 0, "R6 program A8=1");
    run_op(3'd1, 27'h0_01_033, 27'h0, 1, 0, "R6 program single byte");
    run_op(3'd2, 27'h6_BC_D5E, 27'h0, 0, 0, "R7 erase");
    run_op(3'd3, 27'h4_00_C012, 27'h4_11_C0AB, 0, 0, "R8 copy-back");
    run_op(3'd3, 27'h4_00_C012, 27'h4_11_8012, 0, 1, "R8 copy-back reject");
    run_op(3'd3, 27'h0_00_4012, 27'h4_00_4012, 0, 1, "R8 copy-back reject A26");
    id_dev = 8'h79;
    run_op(3'd4, 27'h0, 27'h0, 0, 0, "R10 identify match");
    id_dev = 8'h76;
    run_op(3'd4, 27'h0, 27'h0, 0, 1, "R10 identify mismatch");
    busy_len = 1000;
    run_op(3'd2, 27'h1_23_4567, 27'h0, 0, 1, "R9 busy timeout");
    busy_len = 40;
    run_op(3'd0, 27'h3_FF_E0F, 27'h0, 12, 0, "R9 R11 read after timeout");

    finished = 1;
    finish_run();
  end
endmodule